// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects interrupt events from a USB on-the-go controller core and presents them to a host CPU as one level interrupt line. Endpoint events (transmit and receive, one bit per endpoint) go into one 32-bit event word. Core-level USB events go into a second event word. For each word there is a latched source register and an enable mask. Each of these has a write-ones-to-set alias and a write-ones-to-clear alias. Software can therefore force an event, acknowledge an event, or change its enables without a read-modify-write. A read-only masked view of each word shows which pending events are enabled.

The interrupt line is asserted when an enabled event is pending and the line is armed. Once asserted, the line stays high until software writes the end-of-interrupt location. That write drops the line and re-arms it. If enabled events are still pending, the line asserts again one cycle later. A self-clearing soft-reset bit in a control word returns the event and mask state to empty and re-arms the line.

The CPU reaches the registers over a 32-bit register bus built from two valid/ready channels. The request channel carries the write flag, a byte address and the write data. The response channel carries the read data, and it also acknowledges writes. At most one response is outstanding. While a response waits for `rsp_ready`, `req_ready` stays low and the response data holds still. A request must stay stable until it is accepted.

Top module: `usb_irq_glue`

## Requirements
- R1: After reset, `irq` is low, `rsp_valid` is low, every source, mask and masked word reads zero, and address 0x00 reads the nonzero revision constant (default 0x00020100).
- R2: A one on `ep_evt[i]` for a clock latches bit i of the endpoint source word (address 0x20). Bits 15:0 are transmit endpoints 0..15, bits 31:16 are receive endpoints 0..15, and bit 16 (receive endpoint 0) always reads zero. A one on `core_evt[j]` latches bit 16+j of the core source word (address 0x40). Bits outside 24:16 of that word read zero.
- R3: Writing ones to a source-set alias (0x24 endpoint, 0x44 core) raises those source bits, within the valid bits only. Bit 24 of the core word is the VBUS-drive change event and can be forced this way. Zero bits written to a set alias change nothing.
- R4: Writing ones to a source-clear alias (0x28, 0x48) drops those source bits. If a hardware event hits a bit in the same cycle that a clear write removes it, the bit ends up set.
- R5: The mask word (0x2C, 0x4C) loads the written value, limited to the valid bits. Its set alias (0x30, 0x50) ORs ones in, and its clear alias (0x34, 0x54) removes ones. Reads of any set or clear alias return the current value of the register it modifies.
- R6: The masked view (0x38, 0x58) reads the bitwise AND of source and mask.
- R7: When the line is armed and any masked bit of either word is nonzero at a clock edge, `irq` rises at that edge. It then stays high until an end-of-interrupt write (any data to 0x60), even if the sources are cleared.
- R8: An end-of-interrupt write drops `irq` at its accepting edge and re-arms the line. If masked events are still pending, `irq` rises again one edge later. Otherwise it stays low.
- R9: Writing 1 to bit 0 of the control word (0x04) clears both source words and both masks, drops `irq` and re-arms the line. The control word reads zero.
- R10: A request is accepted on a clock where `req_valid` and `req_ready` are both high. Its response appears on the next cycle with `rsp_valid` high, and response data and `rsp_valid` hold until `rsp_ready` is high. `req_ready` is low while a response is held.
- R11: Writes to a source word at its base address (0x20, 0x40) and to a masked view are ignored. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid (read data or write acknowledge) |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| ep_evt | input | 32 | Endpoint event strobes from the USB core |
| core_evt | input | 9 | Core-level USB event strobes from the USB core |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
The assertions take for granted that reset is asserted before the first checked edge and that the requester keeps a request stable until it is accepted. Event strobes may take any pattern on any cycle, so they need no assumption. The stimulus drives every request, event strobe and response-ready change at the falling clock edge. It holds each request until the rising edge that accepts it and issues the next one only after the previous response has been taken. It drops `rsp_ready` only in the back-pressure test, and there it holds no new request while the response is pending.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  // Sub-register selector inside one event bank (word offset from bank base)
  typedef enum logic [2:0] {
    SEL_SRC   = 3'd0,
    SEL_SSET  = 3'd1,
    SEL_SCLR  = 3'd2,
    SEL_MSK   = 3'd3,
    SEL_MSET  = 3'd4,
    SEL_MCLR  = 3'd5,
    SEL_MVIEW = 3'd6
  } bank_sel_e;

  // Word addresses (byte address >> 2)
  localparam logic [5:0] WA_REV  = 6'h00;
  localparam logic [5:0] WA_CTRL = 6'h01;
  localparam logic [2:0] WA_EP_HI   = 3'b001;  // 0x20..0x38
  localparam logic [2:0] WA_CORE_HI = 3'b010;  // 0x40..0x58
  localparam logic [5:0] WA_EOI  = 6'h18;

  // Valid bits of the endpoint word: TX endpoints low, RX endpoints high, RX ep0 absent
  function automatic logic [31:0] ep_valid_bits(input int tx_n, input int rx_n);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < tx_n; i++) v[i] = 1'b1;
    for (int i = 1; i < rx_n; i++) v[tx_n + i] = 1'b1;
    return v;
  endfunction

  // Valid bits of the core word: a field of width w starting at lsb
  function automatic logic [31:0] core_valid_bits(input int w, input int lsb);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < w; i++) v[lsb + i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/usb_irq_bank.sv
module usb_irq_bank
  import usb_irq_pkg::*;
#(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] hw_evt,
  input  logic         wr_en,
  input  logic [2:0]   sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] src_o,
  output logic         pend_o
);

  logic [W-1:0] src_q, msk_q, src_d, msk_d;
  logic [W-1:0] s_set, s_clr, m_set, m_clr;
  logic         m_load;
  logic [W-1:0] masked;

  always_comb begin
    s_set  = '0;
    s_clr  = '0;
    m_set  = '0;
    m_clr  = '0;
    m_load = 1'b0;
    if (wr_en) begin
      case (sel)
        SEL_SSET: s_set  = wdata;
        SEL_SCLR: s_clr  = wdata;
        SEL_MSK:  m_load = 1'b1;
        SEL_MSET: m_set  = wdata;
        SEL_MCLR: m_clr  = wdata;
        default:  ;
      endcase
    end
  end

  // Hardware events are ORed after the clear so a coincident event survives
  assign src_d = ((src_q & ~s_clr) | s_set | hw_evt) & VALID;
  assign msk_d = (m_load ? wdata : ((msk_q & ~m_clr) | m_set)) & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      msk_q <= '0;
    end else if (soft_clr) begin
      src_q <= '0;
      msk_q <= '0;
    end else begin
      src_q <= src_d;
      msk_q <= msk_d;
    end
  end

  assign masked = src_q & msk_q;

  always_comb begin
    case (sel)
      SEL_SRC, SEL_SSET, SEL_SCLR: rdata = src_q;
      SEL_MSK, SEL_MSET, SEL_MCLR: rdata = msk_q;
      SEL_MVIEW:                   rdata = masked;
      default:                     rdata = '0;
    endcase
  end

  assign src_o  = src_q;
  assign pend_o = |masked;

endmodule

// File: rtl/usb_irq_regbus.sv
module usb_irq_regbus
  import usb_irq_pkg::*;
#(
  parameter int          DW  = 32,
  parameter int          AW  = 8,
  parameter logic [DW-1:0] REV = 32'h0002_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  input  logic [DW-1:0] ep_rdata,
  input  logic [DW-1:0] core_rdata,
  output logic [2:0]    sel,
  output logic [DW-1:0] wdata,
  output logic          ep_wr,
  output logic          core_wr,
  output logic          eoi_wr,
  output logic          soft_clr
);

  localparam int WAW = AW - 2;

  logic [WAW-1:0] wa;
  logic           acc, wr_acc;
  logic           ep_hit, core_hit;
  logic [DW-1:0]  rd_mux;
  logic           rsp_valid_q;
  logic [DW-1:0]  rsp_rdata_q;
  logic [1:0]     unused_lsb;

  assign unused_lsb = req_addr[1:0];
  assign wa         = req_addr[AW-1:2];
  assign req_ready  = !rsp_valid_q || rsp_ready;
  assign acc        = req_valid && req_ready;
  assign wr_acc     = acc && req_write;

  assign ep_hit   = (wa[5:3] == WA_EP_HI)   && (wa[2:0] != 3'd7);
  assign core_hit = (wa[5:3] == WA_CORE_HI) && (wa[2:0] != 3'd7);
  assign sel      = wa[2:0];
  assign wdata    = req_wdata;

  assign ep_wr    = wr_acc && ep_hit;
  assign core_wr  = wr_acc && core_hit;
  assign eoi_wr   = wr_acc && (wa == WA_EOI);
  assign soft_clr = wr_acc && (wa == WA_CTRL) && req_wdata[0];

  always_comb begin
    if (ep_hit)               rd_mux = ep_rdata;
    else if (core_hit)        rd_mux = core_rdata;
    else if (wa == WA_REV)    rd_mux = REV;
    else                      rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (acc) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic eoi_wr,
  input  logic pend,
  output logic irq
);

  logic irq_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (soft_clr || eoi_wr) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (armed_q && pend) begin
      irq_q   <= 1'b1;
      armed_q <= 1'b0;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/usb_irq_glue.sv
module usb_irq_glue
  import usb_irq_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 8,
  parameter int          TX_N     = 16,
  parameter int          RX_N     = 16,
  parameter int          CORE_W   = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV      = 32'h0002_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [DW-1:0]     ep_evt,
  input  logic [CORE_W-1:0] core_evt,
  output logic              irq
);

  localparam logic [DW-1:0] EP_VALID   = DW'(ep_valid_bits(TX_N, RX_N));
  localparam logic [DW-1:0] CORE_VALID = DW'(core_valid_bits(CORE_W, CORE_LSB));

  logic [2:0]    sel;
  logic [DW-1:0] wdata;
  logic          ep_wr, core_wr, eoi_wr, soft_clr;
  logic [DW-1:0] ep_rdata, core_rdata;
  logic [DW-1:0] ep_src, core_src;
  logic          ep_pend, core_pend, pend;
  logic [DW-1:0] core_hw;

  assign core_hw = DW'(core_evt) << CORE_LSB;

  usb_irq_regbus #(.DW(DW), .AW(AW), .REV(REV)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ep_rdata(ep_rdata), .core_rdata(core_rdata),
    .sel(sel), .wdata(wdata), .ep_wr(ep_wr), .core_wr(core_wr),
    .eoi_wr(eoi_wr), .soft_clr(soft_clr)
  );

  usb_irq_bank #(.W(DW), .VALID(EP_VALID)) u_ep (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hw_evt(ep_evt),
    .wr_en(ep_wr), .sel(sel), .wdata(wdata), .rdata(ep_rdata),
    .src_o(ep_src), .pend_o(ep_pend)
  );

  usb_irq_bank #(.W(DW), .VALID(CORE_VALID)) u_core (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hw_evt(core_hw),
    .wr_en(core_wr), .sel(sel), .wdata(wdata), .rdata(core_rdata),
    .src_o(core_src), .pend_o(core_pend)
  );

  assign pend = ep_pend || core_pend;

  usb_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .eoi_wr(eoi_wr),
    .pend(pend), .irq(irq)
  );

endmodule

// File: rtl/usb_irq_glue_chk.sv
module usb_irq_glue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        pend,
  input logic        eoi_wr,
  input logic        soft_clr,
  input logic        ep_evt0,
  input logic        ep_src0,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata
);

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend)); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi_wr && !soft_clr) |=> irq); // R7

  AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(eoi_wr || soft_clr)); // R8

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_evt0 && !soft_clr) |=> ep_src0); // R4

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10

endmodule

bind usb_irq_glue usb_irq_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend), .eoi_wr(eoi_wr),
  .soft_clr(soft_clr), .ep_evt0(ep_evt[0]), .ep_src0(ep_src[0]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_usb_irq_glue.sv
`timescale 1ns/1ps
module sim_usb_irq_glue;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REV = 32'h0002_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, ep_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_glue u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ep_evt(ep_evt), .core_evt(core_evt), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One bus transaction with optional endpoint event driven in the same cycle
  task automatic bus_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] evt, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; ep_evt = evt;
    @(posedge clk);
    #1;
    rd = rsp_rdata;
    req_valid = 1'b0; ep_evt = '0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus_op(1'b1, a, d, '0, dummy);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    bus_op(1'b0, a, '0, '0, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic pulse_ep(input logic [31:0] e);
    @(negedge clk); ep_evt = e;
    @(negedge clk); ep_evt = '0;
  endtask

  task automatic pulse_core(input logic [8:0] e);
    @(negedge clk); core_evt = e;
    @(negedge clk); core_evt = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq low", 32'(irq), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid low", 32'(rsp_valid), 0);
    rd_chk(8'h00, REV, "R1 revision");
    chk(REV != 0, "R1 revision nonzero", REV, 1);
    rd_chk(8'h20, 0, "R1 ep source");
    rd_chk(8'h4C, 0, "R1 core mask");
    rd_chk(8'h58, 0, "R1 core masked");
  endtask

  task automatic t_hw_events();
    pulse_ep(32'hFFFF_FFFF);
    rd_chk(8'h20, 32'hFFFE_FFFF, "R2 ep source, rx ep0 absent");
    pulse_core(9'h1FF);
    rd_chk(8'h40, 32'h01FF_0000, "R2 core field");
    wr32(8'h28, 32'hFFFF_FFFF);
    wr32(8'h48, 32'hFFFF_FFFF);
    rd_chk(8'h20, 0, "R4 ep cleared");
    rd_chk(8'h40, 0, "R4 core cleared");
  endtask

  task automatic t_force();
    wr32(8'h44, 32'h0100_0000);
    rd_chk(8'h40, 32'h0100_0000, "R3 force VBUS-drive bit24");
    wr32(8'h24, 32'h0);
    rd_chk(8'h20, 0, "R3 zero write to set no effect");
    wr32(8'h44, 32'hFE00_FFFF);
    rd_chk(8'h40, 32'h0100_0000, "R3 set outside field ignored");
    wr32(8'h48, 32'h0100_0000);
    rd_chk(8'h40, 0, "R4 core clear");
  endtask

  task automatic t_clear();
    logic [31:0] dummy;
    pulse_ep(32'h5);
    wr32(8'h28, 32'h1);
    rd_chk(8'h20, 32'h4, "R4 partial clear");
    bus_op(1'b1, 8'h28, 32'h4, 32'h4, dummy);
    rd_chk(8'h20, 32'h4, "R4 event wins over clear");
    wr32(8'h28, 32'h4);
    rd_chk(8'h20, 0, "R4 clear without event");
  endtask

  task automatic t_mask();
    wr32(8'h2C, 32'h000F_0003);
    rd_chk(8'h2C, 32'h000E_0003, "R5 mask load valid bits");
    rd_chk(8'h30, 32'h000E_0003, "R5 mask set alias read");
    rd_chk(8'h34, 32'h000E_0003, "R5 mask clear alias read");
    wr32(8'h30, 32'h100);
    rd_chk(8'h2C, 32'h000E_0103, "R5 mask set");
    wr32(8'h34, 32'h1);
    rd_chk(8'h2C, 32'h000E_0102, "R5 mask clear");
    wr32(8'h2C, 32'h0);
    rd_chk(8'h2C, 0, "R5 mask reload zero");
  endtask

  task automatic t_masked();
    wr32(8'h24, 32'h0003_0006);
    rd_chk(8'h24, 32'h0002_0006, "R5 source set alias read");
    rd_chk(8'h28, 32'h0002_0006, "R5 source clear alias read");
    wr32(8'h2C, 32'h4);
    rd_chk(8'h38, 32'h4, "R6 masked view");
    wr32(8'h38, 32'hFFFF_FFFF);
    rd_chk(8'h2C, 32'h4, "R11 masked view write ignored (mask)");
    rd_chk(8'h38, 32'h4, "R11 masked view write ignored (view)");
    wr32(8'h20, 32'h0);
    rd_chk(8'h20, 32'h0002_0006, "R11 source base write ignored");
    rd_chk(8'h7C, 0, "R11 unmapped read zero");
    rd_chk(8'h04, 0, "R9 control reads zero");
    wr32(8'h2C, 32'h0);
    wr32(8'h28, 32'hFFFF_FFFF);
    wr32(8'h60, 32'h0);
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b0, "R8 idle after cleanup", 32'(irq), 0);
  endtask

  task automatic t_irq();
    wr32(8'h50, 32'h0100_0000);
    @(negedge clk);
    chk(irq == 1'b0, "R7 no irq without source", 32'(irq), 0);
    wr32(8'h44, 32'h0100_0000);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq not before next edge", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq asserted", 32'(irq), 1);
    wr32(8'h48, 32'h0100_0000);
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b1, "R7 irq held after source clear", 32'(irq), 1);
    wr32(8'h60, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 eoi drops irq", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 no refire without pending", 32'(irq), 0);
    wr32(8'h44, 32'h0100_0000);
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b1, "R8 rearmed after eoi", 32'(irq), 1);
    wr32(8'h60, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(irq == 1'b0, "R8 eoi drop with pending", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R8 refire with pending", 32'(irq), 1);
    wr32(8'h48, 32'hFFFF_FFFF);
    wr32(8'h54, 32'hFFFF_FFFF);
    wr32(8'h60, 32'h0);
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b0, "R8 quiet after cleanup", 32'(irq), 0);
  endtask

  task automatic t_softrst();
    wr32(8'h30, 32'h1);
    pulse_ep(32'h1);
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq before soft reset", 32'(irq), 1);
    wr32(8'h04, 32'h1);
    @(negedge clk);
    chk(irq == 1'b0, "R9 soft reset drops irq", 32'(irq), 0);
    rd_chk(8'h20, 0, "R9 source cleared");
    rd_chk(8'h2C, 0, "R9 mask cleared");
    wr32(8'h30, 32'h1);
    pulse_ep(32'h1);
    @(negedge clk);
    chk(irq == 1'b1, "R9 rearmed after soft reset", 32'(irq), 1);
    wr32(8'h04, 32'h1);
    @(negedge clk);
    chk(irq == 1'b0, "R9 cleanup", 32'(irq), 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10 response next cycle", 32'(rsp_valid), 1);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 req_ready low while held", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R10 response held", 32'(rsp_valid), 1);
    chk(rsp_rdata == REV, "R10 data held", rsp_rdata, REV);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R10 response consumed", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R10 req_ready back", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hw_events();
    t_force();
    t_clear();
    t_mask();
    t_masked();
    t_irq();
    t_softrst();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule